// File: doc/BRIEF.md
# Shadowed Trim-Setting Register Bank

This block is the addressable storage that sits behind a serial programming link. A dialogue engine decodes each incoming frame into one access: a read or a write, a 7-bit address and 7 bits of data. The engine presents that access here for one clock cycle. One cycle later the bank returns a response. The response carries the read data, or an echo of the written data, and a flag that marks the access as illegal. The engine uses that flag to corrupt the parity of the returned frame. The engine also pulses `link_err` when it sees a parity or framing fault, and the bank records that fault as a sticky flag.

Eight 4-bit settings drive eight output-level buses. Each setting has a working copy that the outputs follow at all times, and a non-volatile copy modelled as a register array. A write to the control address either loads every non-volatile value into the working copies at once, or saves every working copy into the array. A save keeps the bank busy for `SAVE_CYCLES` clocks, and the array is updated when that interval ends. The same address returns a status word when it is read. Two configuration pins decide whether all eight outputs are driven or whether the first four outputs work as two switchable pairs. In the paired case one output of each pair goes high-impedance.

Top module: `trim_regbank`

## Requirements
- R1: After a synchronous reset, every working setting equals its non-volatile value, the status word reads 0 and `out_level` shows the non-volatile contents.
- R2: Address 0x00 reads as 0. A write to it is flagged bad and changes no setting.
- R3: Addresses 0x02–0x07 and 0x10–0x7F are flagged bad on both read and write. Reads from them return 0, and they change no setting.
- R4: A write to address 0x08+k (k = 0..7) stores data bits 3..0 into setting k, and bits 6..4 are ignored. A read returns {3'b000, setting}. `out_level[4k+3:4k]` follows the setting from the cycle after the write. Every write response echoes the written data.
- R5: Writing the control address (0x01) with data bits [1:0] = 01 copies all non-volatile values into the working settings and clears the differ flag.
- R6: Writing 0x01 with bits [1:0] = 10 starts a save. The busy bit reads 1 for exactly `SAVE_CYCLES` cycles after the write. When that interval ends, the array holds the settings as they were, and the differ flag clears.
- R7: While busy, every write is flagged bad and has no effect. Reads are served normally.
- R8: Writing 0x01 with bits [1:0] = 11 is flagged bad and has no effect. Bits [1:0] = 00 is an accepted no-op.
- R9: A read of 0x01 returns the status word as it stood before the access: bit0 = differ (set by any accepted setting write), bit1 = busy, bit2 = transmission error, bit3 = bad access, and bits 6..4 = 0.
- R10: `link_err` sets the transmission-error bit. Any illegal access sets the bad-access bit. Both bits clear after the next accepted access. An illegal access leaves the transmission-error bit set.
- R11: With `cfg_full` = 1, no output is high-impedance. With `cfg_full` = 0, outputs 4..7 stay driven. In that case `pair_sel` = 0 makes outputs 0 and 2 high-impedance, and `pair_sel` = 1 makes outputs 1 and 3 high-impedance.
- R12: Saved values survive a reset: the reload after reset brings back the values of the last completed save.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | One access is presented this cycle |
| acc_rd | input | 1 | 1 = read, 0 = write |
| acc_addr | input | 7 | Register address |
| acc_wdata | input | 7 | Write data |
| link_err | input | 1 | Transmission fault seen by the dialogue engine |
| cfg_full | input | 1 | 1 = all eight outputs driven |
| pair_sel | input | 1 | Selects which output of each pair stays driven |
| rsp_valid | output | 1 | Response valid, one cycle after the access |
| rsp_bad | output | 1 | Access was illegal |
| rsp_data | output | 7 | Read data, or the write-data echo |
| out_level | output | 32 | Eight 4-bit levels; setting k is at [4k+3:4k] |
| out_hiz | output | 8 | Per-output high-impedance request |

## Verification
The hardest state to reach is the save interval. During that interval, writes must be refused while reads still succeed. The commit must also fire on the right edge, and a reset must afterwards reload the committed values rather than the pre-save ones. Directed steps start a save, probe the status word and a setting while busy, attempt a write, and then idle to the commit. Random traffic weighted toward the control address keeps starting new saves, so that accesses of every kind fall inside busy windows at many offsets. A final save-then-reset sequence checks persistence.

// File: rtl/trb_pkg.sv
package trb_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 7;
  localparam int SET_W  = 4;
  localparam logic [ADDR_W-1:0] ID_ADDR  = 7'h00;
  localparam logic [ADDR_W-1:0] CTL_ADDR = 7'h01;
  localparam logic [ADDR_W-1:0] SET_BASE = 7'h08;

  typedef enum logic [1:0] {K_ID, K_CTL, K_SET, K_NONE} acc_kind_e;

  // packed MSB first: bit3 bad, bit2 xerr, bit1 busy, bit0 differ
  typedef struct packed {
    logic bad;
    logic xerr;
    logic busy;
    logic differ;
  } stat_t;

  function automatic logic [DATA_W-1:0] stat_word(input stat_t s);
    return {{(DATA_W-$bits(stat_t)){1'b0}}, s};
  endfunction

  function automatic acc_kind_e classify(input logic [ADDR_W-1:0] a, input int num_out);
    if (a == ID_ADDR)  return K_ID;
    if (a == CTL_ADDR) return K_CTL;
    if (a >= SET_BASE && int'(a) < int'(SET_BASE) + num_out) return K_SET;
    return K_NONE;
  endfunction
endpackage

// File: rtl/trb_decode.sv
module trb_decode
  import trb_pkg::*;
#(
  parameter int NUM_OUT = 8,
  localparam int IDX_W = $clog2(NUM_OUT)
) (
  input  logic              acc_valid,
  input  logic              acc_rd,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [1:0]        op_bits,
  input  logic              busy,
  output acc_kind_e         kind,
  output logic              acc_bad,
  output logic              acc_good,
  output logic              wr_set,
  output logic              do_load,
  output logic              do_save,
  output logic [IDX_W-1:0]  set_idx
);
  logic [ADDR_W-1:0] offs;
  logic bad_c, load_c, save_c, wset_c;

  assign kind    = classify(acc_addr, NUM_OUT);
  assign offs    = acc_addr - SET_BASE;
  assign set_idx = offs[IDX_W-1:0];

  always_comb begin
    bad_c = 1'b0; load_c = 1'b0; save_c = 1'b0; wset_c = 1'b0;
    unique case (kind)
      K_ID:  bad_c = !acc_rd;
      K_CTL: if (!acc_rd) begin
        if (busy || op_bits == 2'b11) bad_c = 1'b1;
        else begin
          load_c = op_bits[0];
          save_c = op_bits[1];
        end
      end
      K_SET: if (!acc_rd) begin
        if (busy) bad_c = 1'b1;
        else      wset_c = 1'b1;
      end
      default: bad_c = 1'b1;
    endcase
  end

  assign acc_bad  = acc_valid && bad_c;
  assign acc_good = acc_valid && !bad_c;
  assign do_load  = acc_valid && load_c;
  assign do_save  = acc_valid && save_c;
  assign wr_set   = acc_valid && wset_c;
endmodule

// File: rtl/trb_savectl.sv
module trb_savectl #(
  parameter int SAVE_CYCLES = 20,
  localparam int CNT_W = $clog2(SAVE_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic commit
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (start)      cnt_q <= CNT_W'(SAVE_CYCLES);
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign busy   = (cnt_q != 0);
  assign commit = (cnt_q == 1);

  AST_SAVE_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);                                             // R7
  AST_COMMIT_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);                                            // R6
endmodule

// File: rtl/trb_outmux.sv
module trb_outmux #(
  parameter int NUM_OUT = 8,
  parameter int PAIRED  = 4
) (
  input  logic               cfg_full,
  input  logic               pair_sel,
  output logic [NUM_OUT-1:0] out_hiz
);
  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    if (i < PAIRED) begin : g_pair
      localparam bit IS_ODD = (i % 2) == 1;
      assign out_hiz[i] = !cfg_full && (pair_sel ? IS_ODD : !IS_ODD);
    end else begin : g_fixed
      assign out_hiz[i] = 1'b0;
    end
  end
endmodule

// File: rtl/trim_regbank.sv
module trim_regbank
  import trb_pkg::*;
#(
  parameter int NUM_OUT     = 8,
  parameter int SAVE_CYCLES = 20,
  parameter logic [NUM_OUT*SET_W-1:0] NV_INIT = '0,
  localparam int IDX_W  = $clog2(NUM_OUT),
  localparam int BANK_W = NUM_OUT * SET_W,
  localparam int PAIRED = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_rd,
  input  logic [6:0]        acc_addr,
  input  logic [6:0]        acc_wdata,
  input  logic              link_err,
  input  logic              cfg_full,
  input  logic              pair_sel,
  output logic              rsp_valid,
  output logic              rsp_bad,
  output logic [6:0]        rsp_data,
  output logic [BANK_W-1:0] out_level,
  output logic [NUM_OUT-1:0] out_hiz
);
  logic [BANK_W-1:0] ram_q;
  logic [BANK_W-1:0] nv_q = NV_INIT;
  logic differ_q, xerr_q, bad_q;

  acc_kind_e        kind;
  logic             acc_bad, acc_good, wr_set, do_load, do_save;
  logic [IDX_W-1:0] set_idx;
  logic             busy, commit;
  stat_t            stat_now;
  logic [DATA_W-1:0] rd_val;

  trb_decode #(.NUM_OUT(NUM_OUT)) u_dec (
    .acc_valid(acc_valid), .acc_rd(acc_rd), .acc_addr(acc_addr),
    .op_bits(acc_wdata[1:0]), .busy(busy), .kind(kind),
    .acc_bad(acc_bad), .acc_good(acc_good), .wr_set(wr_set),
    .do_load(do_load), .do_save(do_save), .set_idx(set_idx)
  );

  trb_savectl #(.SAVE_CYCLES(SAVE_CYCLES)) u_save (
    .clk(clk), .rst_n(rst_n), .start(do_save), .busy(busy), .commit(commit)
  );

  trb_outmux #(.NUM_OUT(NUM_OUT), .PAIRED(PAIRED)) u_mux (
    .cfg_full(cfg_full), .pair_sel(pair_sel), .out_hiz(out_hiz)
  );

  // non-volatile array: no reset, written only at the end of a save
  always_ff @(posedge clk) begin
    if (commit) nv_q <= ram_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || do_load) ram_q <= nv_q;
    else if (wr_set)       ram_q[set_idx*SET_W +: SET_W] <= acc_wdata[SET_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      differ_q <= 1'b0;
      xerr_q   <= 1'b0;
      bad_q    <= 1'b0;
    end else begin
      if (wr_set)                 differ_q <= 1'b1;
      else if (do_load || commit) differ_q <= 1'b0;
      if (link_err)      xerr_q <= 1'b1;
      else if (acc_good) xerr_q <= 1'b0;
      if (acc_bad)       bad_q <= 1'b1;
      else if (acc_good) bad_q <= 1'b0;
    end
  end

  assign stat_now = '{bad: bad_q, xerr: xerr_q, busy: busy, differ: differ_q};

  always_comb begin
    unique case (kind)
      K_CTL:   rd_val = stat_word(stat_now);
      K_SET:   rd_val = {{(DATA_W-SET_W){1'b0}}, ram_q[set_idx*SET_W +: SET_W]};
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_bad   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= acc_valid;
      rsp_bad   <= acc_bad;
      rsp_data  <= acc_rd ? rd_val : acc_wdata;
    end
  end

  assign out_level = ram_q;

  AST_UNUSED_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && kind == K_NONE |=> rsp_bad && bad_q);            // R3
  AST_ID_WRITE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_rd && acc_addr == ID_ADDR |=> rsp_bad);     // R2
  AST_BUSY_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && acc_valid && !acc_rd |=> rsp_bad);                    // R7
  AST_RAM_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(ram_q));                                     // R7
  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> ram_q == $past(nv_q) && !differ_q);               // R5
  AST_COMMIT_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> nv_q == $past(ram_q) && !differ_q);                // R6
  AST_GOOD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_good && !link_err |=> !bad_q && !xerr_q);                 // R10
  AST_FULL_NO_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_full |-> out_hiz == '0);                                  // R11
  AST_PAIR_HALF_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_full |-> $countones(out_hiz) == PAIRED / 2);             // R11
endmodule

// File: tb/sim_trim_regbank.sv
`timescale 1ns/1ps
module sim_trim_regbank;
  localparam int N = 8;
  localparam int SAVE_N = 12;
  localparam logic [31:0] NV0 = 32'h9E3C_5A17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0, acc_rd = 1'b0, link_err = 1'b0;
  logic [6:0] acc_addr = '0, acc_wdata = '0;
  logic cfg_full = 1'b1, pair_sel = 1'b0;
  logic rsp_valid, rsp_bad;
  logic [6:0] rsp_data;
  logic [31:0] out_level;
  logic [7:0] out_hiz;

  always #2.5 clk = ~clk;

  trim_regbank #(.NUM_OUT(N), .SAVE_CYCLES(SAVE_N), .NV_INIT(NV0)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_rd(acc_rd),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .link_err(link_err),
    .cfg_full(cfg_full), .pair_sel(pair_sel), .rsp_valid(rsp_valid),
    .rsp_bad(rsp_bad), .rsp_data(rsp_data), .out_level(out_level), .out_hiz(out_hiz)
  );

  int n_cmp = 0, n_bad = 0;
  logic [3:0] m_ram [N];
  logic [3:0] m_nv  [N];
  bit m_differ, m_xerr, m_bad;
  int m_busy;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // 0 id, 1 control, 2 setting, 3 unused
  function automatic int kind_of(input logic [6:0] a);
    if (a == 7'h00) return 0;
    if (a == 7'h01) return 1;
    if (a >= 7'h08 && a <= 7'h0F) return 2;
    return 3;
  endfunction

  function automatic logic [31:0] exp_level();
    logic [31:0] v;
    for (int i = 0; i < N; i++) v[i*4 +: 4] = m_ram[i];
    return v;
  endfunction

  function automatic logic [7:0] exp_hiz(input bit full, input bit ps);
    logic [7:0] h = '0;
    for (int i = 0; i < 4; i++) h[i] = !full && (ps ? (i % 2 == 1) : (i % 2 == 0));
    return h;
  endfunction

  function automatic bit exp_is_bad(input bit rd, input logic [6:0] a, input logic [6:0] wd);
    case (kind_of(a))
      0: return !rd;
      1: return !rd && (m_busy > 0 || wd[1:0] == 2'b11);
      2: return !rd && m_busy > 0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [6:0] exp_data(input bit rd, input logic [6:0] a, input logic [6:0] wd);
    if (!rd) return wd;
    case (kind_of(a))
      1: return {3'b000, m_bad, m_xerr, (m_busy > 0), m_differ};
      2: return {3'b000, m_ram[a - 7'h08]};
      default: return 7'h00;
    endcase
  endfunction

  function automatic string auto_tag(input bit rd, input logic [6:0] a);
    if (m_busy > 0 && !rd) return "R7";
    case (kind_of(a))
      0: return "R2";
      1: return rd ? "R9" : "R8";
      2: return "R4";
      default: return "R3";
    endcase
  endfunction

  // one cycle: drive at negedge, edge, compare at next negedge
  task automatic step(input bit v, input bit rd, input logic [6:0] a,
                      input logic [6:0] wd, input bit lerr, input string tag);
    bit eb; logic [6:0] ed; string t;
    eb = v && exp_is_bad(rd, a, wd);
    ed = exp_data(rd, a, wd);
    t  = (tag == "") ? auto_tag(rd, a) : tag;
    acc_valid = v; acc_rd = rd; acc_addr = a; acc_wdata = wd; link_err = lerr;
    @(posedge clk);
    if (m_busy == 1) begin
      for (int i = 0; i < N; i++) m_nv[i] = m_ram[i];
      m_differ = 1'b0;
    end
    if (m_busy > 0) m_busy--;
    if (v && !eb && !rd) begin
      if (kind_of(a) == 2) begin
        m_ram[a - 7'h08] = wd[3:0];
        m_differ = 1'b1;
      end else if (kind_of(a) == 1) begin
        if (wd[0]) begin
          for (int i = 0; i < N; i++) m_ram[i] = m_nv[i];
          m_differ = 1'b0;
        end
        if (wd[1]) m_busy = SAVE_N;
      end
    end
    if (v) begin
      if (eb) m_bad = 1'b1;
      else begin m_bad = 1'b0; m_xerr = 1'b0; end
    end
    if (lerr) m_xerr = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0; link_err = 1'b0;
    if (v) begin
      check({t, " rsp_valid"}, 32'(rsp_valid), 32'd1);
      check({t, " rsp_bad"}, 32'(rsp_bad), 32'(eb));
      check({t, " rsp_data"}, 32'(rsp_data), 32'(ed));
    end
    check("R4 out_level", out_level, exp_level());
    check("R11 out_hiz", 32'(out_hiz), 32'(exp_hiz(cfg_full, pair_sel)));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b1, 7'h00, 7'h00, 1'b0, "");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < N; i++) m_ram[i] = m_nv[i];
    m_differ = 0; m_xerr = 0; m_bad = 0; m_busy = 0;
  endtask

  initial begin : watchdog
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    logic [6:0] a, wd;
    for (int i = 0; i < N; i++) m_nv[i] = NV0[i*4 +: 4];
    seed = $urandom(32'h1D5E_0BA7);
    do_reset();

    // R1 reset state
    check("R1 out_level after reset", out_level, NV0);
    step(1, 1, 7'h01, 0, 0, "R1 status");
    for (int k = 0; k < N; k++) step(1, 1, 7'(8 + k), 0, 0, "R1 setting");

    // R2, R9, R10
    step(1, 1, 7'h00, 0, 0, "R2 id read");
    step(1, 0, 7'h00, 7'h55, 0, "R2 id write");
    step(1, 1, 7'h01, 0, 0, "R9 bad bit");
    step(1, 1, 7'h01, 0, 0, "R10 bad cleared");

    // R3
    step(1, 1, 7'h05, 0, 0, "R3 low unused read");
    step(1, 0, 7'h40, 7'h0F, 0, "R3 high unused write");
    step(1, 1, 7'h7F, 0, 0, "R3 top unused read");

    // R4 upper bits ignored
    step(1, 0, 7'h09, 7'h7B, 0, "R4 write");
    step(1, 1, 7'h09, 0, 0, "R4 readback");
    step(1, 1, 7'h01, 0, 0, "R9 differ");

    // R8
    step(1, 0, 7'h01, 7'h03, 0, "R8 both bits");
    step(1, 0, 7'h01, 7'h00, 0, "R8 no-op");

    // R5
    step(1, 0, 7'h01, 7'h01, 0, "R5 load");
    step(1, 1, 7'h09, 0, 0, "R5 reloaded");
    step(1, 1, 7'h01, 0, 0, "R5 differ clear");

    // R6, R7
    step(1, 0, 7'h0C, 7'h06, 0, "R4 write");
    step(1, 0, 7'h01, 7'h02, 0, "R6 save");
    step(1, 1, 7'h01, 0, 0, "R6 busy");
    step(1, 0, 7'h0C, 7'h0A, 0, "R7 write blocked");
    step(1, 1, 7'h0C, 0, 0, "R7 read while busy");
    step(1, 0, 7'h01, 7'h01, 0, "R7 load blocked");
    idle(SAVE_N);
    step(1, 1, 7'h01, 0, 0, "R6 done");

    // R10 transmission error
    step(0, 1, 7'h00, 0, 1, "R10 pulse");
    step(1, 1, 7'h01, 0, 0, "R10 xerr seen");
    step(1, 1, 7'h01, 0, 0, "R10 xerr cleared");
    step(0, 1, 7'h00, 0, 1, "R10 pulse");
    step(1, 1, 7'h20, 0, 0, "R10 bad access");
    step(1, 1, 7'h01, 0, 0, "R10 both set");

    // R11
    for (int c = 0; c < 4; c++) begin
      cfg_full = c[1]; pair_sel = c[0];
      step(1, 1, 7'h08, 0, 0, "R11 config");
    end

    // random traffic
    for (int n = 0; n < 600; n++) begin
      int r = $urandom_range(0, 9);
      if (r < 3)      a = 7'h01;
      else if (r < 7) a = 7'(8 + $urandom_range(0, 7));
      else if (r < 8) a = 7'h00;
      else            a = 7'($urandom_range(0, 127));
      wd = 7'($urandom);
      if ($urandom_range(0, 15) == 0) begin
        cfg_full = $urandom_range(0, 1) == 1;
        pair_sel = $urandom_range(0, 1) == 1;
      end
      if ($urandom_range(0, 5) == 0) step(0, 1, 7'h00, 0, $urandom_range(0, 1) == 1, "");
      else step(1, $urandom_range(0, 1) == 1, a, wd, 1'b0, "");
    end
    idle(SAVE_N + 1);

    // R12 persistence across reset
    step(1, 0, 7'h0F, 7'h03, 0, "R12 write");
    step(1, 0, 7'h08, 7'h0D, 0, "R12 write");
    step(1, 0, 7'h01, 7'h02, 0, "R12 save");
    idle(SAVE_N + 2);
    step(1, 0, 7'h0F, 7'h0E, 0, "R12 unsaved write");
    do_reset();
    check("R12 level after reset", out_level, exp_level());
    step(1, 1, 7'h0F, 0, 0, "R12 saved value");
    step(1, 1, 7'h08, 0, 0, "R12 saved value");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule